// File: doc/BRIEF.md
# Debug Memory Access Port

This block gives a debug host a register window onto a small byte-addressed memory. The host sees three registers: a control word that selects the access size and the address-step behaviour, a transfer address, and a data register. Reading or writing the data register performs one memory access at the transfer address. The bytes are steered to or from the byte lanes of the 32-bit data word, and the address may then advance. A block transfer is simply a run of data-register accesses, each starting at the address the previous one left behind.

Each request lasts one cycle and carries a register select, a read/write flag and a 32-bit write word. A response strobe follows one cycle later, and for reads it carries the result. The block contains a behavioural backing memory, preloaded with a counting pattern so that reads return known values. Accesses that would run past the end of that memory are handled quietly: writes are dropped and reads fill the missing lanes with zeros. A data access with a setting the block cannot perform is refused, and a sticky error flag is raised.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset the control word and the transfer address read as zero, and the data register holds zero.
- R2: Select code 0 is the control word, 1 is the transfer address, 3 is the data register, and 2 is reserved: it reads zero and ignores writes. The control word reads as size code in bits 2:0 (0 = byte, 1 = halfword, 2 = word), step mode in bits 5:4 (0 = hold, 1 = advance, 2 = packed), the error flag in bit 7, and zeros elsewhere. Reading the control word or the transfer address performs no memory access.
- R3: A word access moves four consecutive bytes starting at the transfer address, on any alignment. The lowest address occupies bits 7:0.
- R4: A byte or halfword write shifts the write word right by 8 × (address mod 4) and stores the low one or two bytes at the address.
- R5: A byte or halfword read places the fetched data at bit offset 8 × (address mod 4) of the data register. All other bits keep their previous values.
- R6: In advance mode every performed data access adds 1, 2 or 4 to the transfer address, matching the size. In hold mode the address does not change.
- R7: A write whose address plus access width exceeds the memory size changes no memory byte and leaves the transfer address unchanged. The data register still takes the written word.
- R8: A read whose address plus access width exceeds the memory size fetches zeros into its lanes, and the address still advances in advance mode.
- R9: Memory byte i initially holds (i mod 255) + 1.
- R10: A data access with step mode 2 or 3, or with size code above 2, changes no memory byte, address or data register and sets the error flag. The flag stays set until a control-word write with bit 7 set clears it.
- R11: Every request produces rsp_valid exactly one cycle later, and no response appears without a request. For reads, rsp_rdata carries the register value after the access; for writes it is zero.
- R12: Back-to-back data accesses chain: each one uses the address left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_sel | input | 2 | Register select (0 control, 1 address, 3 data) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read result (zero for writes) |

## Verification
Word reads at aligned addresses, at unaligned addresses and across the 255-byte wrap of the preload pattern show whether the byte order and the memory contents are right. Byte and halfword reads at every lane offset, made over a known data-register value, separate a correct merge from zero extension and from a wrong lane. Narrow and unaligned writes, each read back as whole words, confirm that the right bytes and only those changed. Accesses that straddle or start past the end of memory, and refused settings followed by flag clearing, check address stepping in the cases where it must and must not happen.

// File: rtl/dmp_pkg.sv
`timescale 1ns/1ps
package dmp_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_RSVD = 2'd2,
      SEL_DATA = 2'd3
   } dmp_sel_e;

   typedef enum logic [1:0] {
      STEP_HOLD   = 2'd0,
      STEP_ADV    = 2'd1,
      STEP_PACKED = 2'd2,
      STEP_RSVD   = 2'd3
   } dmp_step_e;

   localparam logic [2:0] SZ_BYTE = 3'd0;
   localparam logic [2:0] SZ_HALF = 3'd1;
   localparam logic [2:0] SZ_WORD = 3'd2;

   localparam int unsigned LANES = 4;

   // Access width in bytes; zero marks a size the port cannot perform.
   function automatic logic [2:0] size_bytes(input logic [2:0] code);
      case (code)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         SZ_WORD: size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/dmp_ctrl.sv
`timescale 1ns/1ps
module dmp_ctrl
   import dmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_size,
   input  logic [1:0] wr_step,
   input  logic       wr_clr,
   input  logic       err_set,
   output logic [2:0] size_q,
   output dmp_step_e  step_q,
   output logic       err_q,
   output logic [31:0] word
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= SZ_BYTE;
         step_q <= STEP_HOLD;
         err_q  <= 1'b0;
      end else begin
         if (wr_en) begin
            size_q <= wr_size;
            step_q <= dmp_step_e'(wr_step);
            if (wr_clr) err_q <= 1'b0;
         end
         if (err_set) err_q <= 1'b1;
      end
   end

   assign word = {24'd0, err_q, 1'b0, step_q, 1'b0, size_q};

endmodule

// File: rtl/dmp_lane.sv
`timescale 1ns/1ps
module dmp_lane
   import dmp_pkg::*;
#(
   parameter int unsigned DW = 32
)(
   input  logic [2:0]    size,
   input  logic [1:0]    lane,
   input  logic [DW-1:0] old_word,
   input  logic [DW-1:0] fetched,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_word,
   output logic [DW-1:0] wr_bytes,
   output logic [LANES-1:0] wr_be
);

   localparam int unsigned SHW = $clog2(DW);

   logic [SHW-1:0] sh;
   logic [2:0]     nbytes;
   logic [DW-1:0]  shifted;

   if (DW != 32) begin : g_bad_dw
      $error("dmp_lane: data word must be 32 bits");
   end

   assign sh      = SHW'({lane, 3'b000});
   assign nbytes  = size_bytes(size);
   assign shifted = wdata >> sh;

   always_comb begin
      case (size)
         SZ_BYTE: rd_word = (old_word & ~(DW'(8'hFF) << sh))
                          | (DW'(fetched[7:0]) << sh);
         SZ_HALF: rd_word = (old_word & ~(DW'(16'hFFFF) << sh))
                          | (DW'(fetched[15:0]) << sh);
         default: rd_word = fetched;
      endcase
   end

   assign wr_bytes = (size == SZ_WORD) ? wdata : shifted;

   for (genvar k = 0; k < LANES; k++) begin : g_be
      assign wr_be[k] = (32'(nbytes) > k);
   end

endmodule

// File: rtl/dmp_mem.sv
`timescale 1ns/1ps
module dmp_mem
   import dmp_pkg::*;
#(
   parameter int unsigned BYTES   = 2048,
   parameter int unsigned AW      = 11,
   parameter bit          PRELOAD = 1'b1
)(
   input  logic             clk,
   input  logic [AW-1:0]    base,
   input  logic [LANES-1:0] we,
   input  logic [31:0]      wr_bytes,
   output logic [31:0]      rd_bytes
);

   logic [7:0] store [BYTES];

   if (AW != $clog2(BYTES)) begin : g_bad_aw
      $error("dmp_mem: AW does not match BYTES");
   end

   if (PRELOAD) begin : g_pattern
      initial begin
         for (int i = 0; i < int'(BYTES); i++) store[i] = 8'((i % 255) + 1);
      end
   end else begin : g_blank
      initial begin
         for (int i = 0; i < int'(BYTES); i++) store[i] = 8'd0;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_rd
      localparam logic [AW-1:0] OFS = AW'(k);
      assign rd_bytes[8*k +: 8] = store[base + OFS];
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < int'(LANES); k++) begin
         if (we[k]) store[base + AW'(k)] <= wr_bytes[8*k +: 8];
      end
   end

endmodule

// File: rtl/dbg_mem_port.sv
`timescale 1ns/1ps
module dbg_mem_port
   import dmp_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 2048,
   parameter bit          PRELOAD   = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_sel,
   input  logic        req_write,
   input  logic [31:0] req_wdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata
);

   localparam int unsigned AW = $clog2(MEM_BYTES);

   if (MEM_BYTES < 4 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_size
      $error("dbg_mem_port: MEM_BYTES must be a power of two of at least 4");
   end

   logic [31:0]      tar_q;
   logic [31:0]      drw_q;
   logic [2:0]       size_q;
   dmp_step_e        step_q;
   logic             err_q;
   logic [31:0]      ctrl_word;
   logic [2:0]       nbytes;
   logic             data_acc;
   logic             can_do;
   logic [32:0]      end_addr;
   logic             in_range;
   logic [31:0]      raw_bytes;
   logic [31:0]      fetched;
   logic [31:0]      merged;
   logic [31:0]      wr_bytes;
   logic [LANES-1:0] lane_be;
   logic [LANES-1:0] mem_we;
   logic             advance;
   logic [31:0]      rd_mux;

   assign data_acc = req_valid && (dmp_sel_e'(req_sel) == SEL_DATA);
   assign nbytes   = size_bytes(size_q);
   assign can_do   = (nbytes != 3'd0) && (step_q == STEP_HOLD || step_q == STEP_ADV);
   assign end_addr = {1'b0, tar_q} + 33'(nbytes);
   assign in_range = end_addr <= 33'(MEM_BYTES);
   assign fetched  = in_range ? raw_bytes : 32'd0;
   assign mem_we   = lane_be & {LANES{data_acc && req_write && can_do && in_range}};
   assign advance  = data_acc && can_do && (step_q == STEP_ADV) && (!req_write || in_range);

   dmp_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (req_valid && req_write && dmp_sel_e'(req_sel) == SEL_CTRL),
      .wr_size (req_wdata[2:0]),
      .wr_step (req_wdata[5:4]),
      .wr_clr  (req_wdata[7]),
      .err_set (data_acc && !can_do),
      .size_q  (size_q),
      .step_q  (step_q),
      .err_q   (err_q),
      .word    (ctrl_word)
   );

   dmp_lane #(.DW(32)) u_lane (
      .size     (size_q),
      .lane     (tar_q[1:0]),
      .old_word (drw_q),
      .fetched  (fetched),
      .wdata    (req_wdata),
      .rd_word  (merged),
      .wr_bytes (wr_bytes),
      .wr_be    (lane_be)
   );

   dmp_mem #(.BYTES(MEM_BYTES), .AW(AW), .PRELOAD(PRELOAD)) u_mem (
      .clk      (clk),
      .base     (tar_q[AW-1:0]),
      .we       (mem_we),
      .wr_bytes (wr_bytes),
      .rd_bytes (raw_bytes)
   );

   always_comb begin
      case (dmp_sel_e'(req_sel))
         SEL_CTRL: rd_mux = ctrl_word;
         SEL_ADDR: rd_mux = tar_q;
         SEL_DATA: rd_mux = can_do ? merged : drw_q;
         default:  rd_mux = 32'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tar_q     <= 32'd0;
         drw_q     <= 32'd0;
         rsp_valid <= 1'b0;
         rsp_rdata <= 32'd0;
      end else begin
         if (req_valid && req_write && dmp_sel_e'(req_sel) == SEL_ADDR)
            tar_q <= req_wdata;
         else if (advance)
            tar_q <= tar_q + 32'(nbytes);
         if (data_acc && can_do)
            drw_q <= req_write ? req_wdata : merged;
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'd0;
      end
   end

endmodule

// File: rtl/dmp_chk.sv
`timescale 1ns/1ps
module dmp_chk #(
   parameter int unsigned MEM_BYTES = 2048
)(
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  req_sel,
   input logic        req_write,
   input logic        req_clr,
   input logic        rsp_valid,
   input logic [31:0] tar_q,
   input logic        err_q,
   input logic [2:0]  size_q,
   input logic [1:0]  step_q
);

   logic acc;
   assign acc = req_valid && req_sel == 2'd3;

   a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r6_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && step_q == 2'd0) |=> $stable(tar_q));

   a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write && step_q == 2'd1 && size_q <= 3'd2)
      |=> tar_q == $past(tar_q) + (32'd1 << $past(size_q)));

   a_r7_drop_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write && size_q <= 3'd2
       && ({1'b0, tar_q} + (33'd1 << size_q)) > 33'(MEM_BYTES))
      |=> $stable(tar_q));

   a_r10_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (size_q > 3'd2 || step_q[1])) |=> err_q);

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(req_valid && req_sel == 2'd0 && req_write && req_clr)) |=> err_q);

endmodule

bind dbg_mem_port dmp_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_sel   (req_sel),
   .req_write (req_write),
   .req_clr   (req_wdata[7]),
   .rsp_valid (rsp_valid),
   .tar_q     (tar_q),
   .err_q     (err_q),
   .size_q    (size_q),
   .step_q    (step_q)
);

// File: tb/sim_dbg_mem_port.sv
`timescale 1ns/1ps
module sim_dbg_mem_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_sel = 2'd0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = 32'd0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q [$];
   bit          want_q[$];
   string       tag_q [$];
   logic [31:0] e_val;
   bit          e_want;
   string       e_tag;

   localparam logic [1:0] CTRL = 2'd0, ADDR = 2'd1, RSVD = 2'd2, DATA = 2'd3;

   dbg_mem_port u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   always #5 clk = ~clk;

   task automatic issue(input logic [1:0] sel, input logic wr, input logic [31:0] d,
                        input bit want, input logic [31:0] ex, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_write = wr; req_wdata = d;
      exp_q.push_back(ex); want_q.push_back(want); tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      issue(sel, 1'b1, d, 1'b0, 32'd0, "");
   endtask

   task automatic rd(input logic [1:0] sel, input logic [31:0] ex, input string tag);
      issue(sel, 1'b0, 32'd0, 1'b1, ex, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_write = 1'b0;
      end
   endtask

   task automatic report;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11 response without request: got %08h expected none", rsp_rdata);
         end else begin
            e_val = exp_q.pop_front(); e_want = want_q.pop_front(); e_tag = tag_q.pop_front();
            if (e_want) begin
               n_chk++;
               if (rsp_rdata !== e_val) begin
                  n_fail++;
                  $display("FAIL %s actual %08h expected %08h", e_tag, rsp_rdata, e_val);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0 || rsp_rdata !== 32'd0) begin
         n_fail++;
         $display("FAIL R1 idle outputs actual %b/%08h expected 0/00000000", rsp_valid, rsp_rdata);
      end
      // R1 reset values; reset size byte, hold mode
      rd(CTRL, 32'h0, "R1 ctrl reset");
      rd(ADDR, 32'h0, "R1 addr reset");
      rd(DATA, 32'h0000_0001, "R1 R9 byte 0 into zero data reg");
      rd(ADDR, 32'h0, "R6 hold mode keeps address");
      // R2 register readback and reserved select
      wr(CTRL, 32'h12);
      rd(CTRL, 32'h12, "R2 ctrl readback");
      rd(RSVD, 32'h0, "R2 reserved reads zero");
      wr(RSVD, 32'hFFFF_FFFF);
      rd(CTRL, 32'h12, "R2 reserved write ignored ctrl");
      // R3 aligned and unaligned words
      wr(ADDR, 32'h10);
      rd(DATA, 32'h1413_1211, "R3 aligned word");
      rd(ADDR, 32'h14, "R6 word step");
      wr(ADDR, 32'h101);
      rd(DATA, 32'h0605_0403, "R3 unaligned word");
      wr(ADDR, 32'd253);
      rd(DATA, 32'h0201_FFFE, "R9 pattern wrap");
      // R5 narrow reads merge
      wr(CTRL, 32'h11);
      wr(ADDR, 32'h22);
      rd(DATA, 32'h2423_FFFE, "R5 halfword lane 2 merge");
      rd(ADDR, 32'h24, "R6 halfword step");
      wr(CTRL, 32'h10);
      wr(ADDR, 32'h07);
      rd(DATA, 32'h0823_FFFE, "R5 byte lane 3 merge");
      rd(ADDR, 32'h08, "R6 byte step");
      // R4 narrow writes
      wr(CTRL, 32'h11);
      wr(ADDR, 32'h42);
      wr(DATA, 32'hABCD_1234);
      rd(ADDR, 32'h44, "R6 halfword write step");
      wr(CTRL, 32'h02);
      wr(ADDR, 32'h40);
      rd(DATA, 32'hABCD_4241, "R4 halfword write lane 2");
      rd(ADDR, 32'h40, "R6 hold after word read");
      wr(CTRL, 32'h10);
      wr(ADDR, 32'h81);
      wr(DATA, 32'h0000_5A00);
      rd(ADDR, 32'h82, "R6 byte write step");
      wr(CTRL, 32'h02);
      wr(ADDR, 32'h80);
      rd(DATA, 32'h8483_5A81, "R4 byte write lane 1");
      // R3 unaligned word write, R12 chained reads
      wr(CTRL, 32'h12);
      wr(ADDR, 32'h203);
      wr(DATA, 32'h1122_3344);
      rd(ADDR, 32'h207, "R6 word write step");
      wr(ADDR, 32'h200);
      rd(DATA, 32'h4405_0403, "R3 unaligned write low part");
      rd(DATA, 32'h0A11_2233, "R12 R3 unaligned write high part");
      // R12 block transfer
      wr(ADDR, 32'h300);
      wr(DATA, 32'hA0A1_A2A3);
      wr(DATA, 32'hB0B1_B2B3);
      wr(DATA, 32'hC0C1_C2C3);
      rd(ADDR, 32'h30C, "R12 block write address");
      wr(ADDR, 32'h300);
      rd(DATA, 32'hA0A1_A2A3, "R12 beat 0");
      rd(DATA, 32'hB0B1_B2B3, "R12 beat 1");
      rd(DATA, 32'hC0C1_C2C3, "R12 beat 2");
      // R7 out-of-range write
      wr(ADDR, 32'h7FE);
      wr(DATA, 32'hDEAD_BEEF);
      rd(ADDR, 32'h7FE, "R7 dropped write keeps address");
      wr(CTRL, 32'h11);
      rd(DATA, 32'h0807_BEEF, "R7 R5 memory untouched by dropped write");
      // R8 out-of-range reads
      rd(DATA, 32'h0807_0000, "R8 halfword past end reads zero");
      rd(ADDR, 32'h802, "R8 address advances");
      wr(CTRL, 32'h12);
      wr(ADDR, 32'h7FE);
      rd(DATA, 32'h0, "R8 straddling word reads zero");
      rd(ADDR, 32'h802, "R8 straddling read advances");
      // R10 refused accesses and sticky flag
      wr(CTRL, 32'h22);
      wr(ADDR, 32'h10);
      rd(DATA, 32'h0, "R10 packed access refused");
      rd(ADDR, 32'h10, "R10 refused access keeps address");
      rd(CTRL, 32'hA2, "R10 flag set");
      wr(CTRL, 32'h12);
      rd(CTRL, 32'h92, "R10 flag sticky");
      wr(CTRL, 32'h93);
      rd(CTRL, 32'h13, "R10 flag cleared");
      rd(DATA, 32'h0, "R10 oversize access refused");
      rd(CTRL, 32'h93, "R10 flag set by size");
      rd(ADDR, 32'h10, "R10 oversize keeps address");
      wr(CTRL, 32'h82);
      wr(ADDR, 32'h10);
      rd(DATA, 32'h1413_1211, "R10 refused write left memory");
      rd(CTRL, 32'h02, "R10 flag cleared again");
      idle(4);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R11 pending responses actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      report();
      $finish;
   end

endmodule